// File: doc/BRIEF.md
# Pointer Masking Address Transformer

This block sits between address generation and translation in a 64-bit core. It takes the effective address of a memory access. The upper bits of that address may carry a software tag. The block turns it into the address that the translation stage sees. Three virtual addressing widths are supported: 39, 48 and 57 significant bits. There is also a bare setting with no translation. When masking is active for an access, the tag bits between the top significant bit and bit 63 are replaced by copies of the top significant bit. Bit 63 passes through unchanged, so the existing split between the kernel and user halves of the address space still holds. An access whose bit 63 disagrees with the top significant bit is flagged as an address fault.

Each privilege level has its own enable for masking. The block picks the enable that governs each access. An ordinary data access uses the enable of the level that issues it. A hypervisor-style load or store uses the enable of the level it targets. Instruction fetches and table-jump fetches are never masked as data. When a fault is raised, the trap value output carries the transformed address, so a trap handler never needs to know about masking. The result is registered, one cycle after the request.

Top module: `pm_addr_xform`

## Requirements
- R1: While reset is asserted and after it is released with no request, rsp_valid, rsp_fault, rsp_addr and rsp_tval are all zero.
- R2: A request sampled with req_valid high produces rsp_valid high on the following cycle. A cycle without req_valid gives rsp_valid low and leaves rsp_addr, rsp_fault and rsp_tval unchanged.
- R3: Let N be 39, 48 or 57 for req_mode 0, 1 or 2. For a masked access, rsp_addr bits [62:N] equal request bit N-1, and bits [N-1:0] and bit 63 are copied from the request. In the 57-bit mode this leaves exactly 6 tag bits.
- R4: A masked access raises rsp_fault exactly when request bit 63 differs from request bit N-1.
- R5: An unmasked data access (enable off for the governing level) returns the address unchanged. It faults unless bits [63:N-1] are all equal.
- R6: req_mode 3 (bare) returns the address unchanged and never faults.
- R7: When rsp_fault is high, rsp_tval equals the transformed rsp_addr. Otherwise rsp_tval is zero.
- R8: For req_kind 0 (data), the governing level is req_priv (0 user, 1 supervisor, 3 machine) and masking is on when pm_en[req_priv] is 1. The reserved level 2 is always treated as unmasked.
- R9: For req_kind 1 (hypervisor-style data), the governing level is req_tgt_priv, not req_priv.
- R10: req_kind 2 (instruction fetch) and req_kind 3 (table-jump fetch) are never masked. They return the address unchanged with the R5 check.
- R11: For the two halves of a split misaligned access at A and A+k, where the offset does not carry into bit N-1, the transformed second address equals the transformed first address plus k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 64 | Effective address, possibly tagged |
| req_mode | input | 2 | 0: 39-bit, 1: 48-bit, 2: 57-bit, 3: bare |
| req_priv | input | 2 | Issuing privilege level |
| req_tgt_priv | input | 2 | Target level of a hypervisor-style access |
| req_kind | input | 2 | 0 data, 1 hypervisor data, 2 fetch, 3 table-jump fetch |
| pm_en | input | 4 | Masking enable per privilege level, indexed by level |
| rsp_valid | output | 1 | Result present |
| rsp_addr | output | 64 | Address handed to translation |
| rsp_fault | output | 1 | Address fault |
| rsp_tval | output | 64 | Trap value: transformed address on a fault, else zero |

## Verification
The registers that hold internal state are the single result stage and its valid flag. A wrong value in either shows at the ports in the cycle right after the request. It appears as a stale or missing rsp_valid, as tag bits left in rsp_addr, or as an rsp_tval that differs from rsp_addr on a fault. A wrong enable selection shows at once as an unchanged tagged address, and usually as a spurious fault. Because of this, every stimulus vector is checked on the next cycle, and hold behaviour is checked on the idle cycle that follows.

// File: rtl/pm_xform_pkg.sv
package pm_xform_pkg;
  localparam int unsigned NUM_SV_MODES = 3;
  localparam int unsigned PRIV_W       = 2;
  localparam int unsigned RSV_PRIV     = 2;

  typedef enum logic [1:0] {
    VA39    = 2'd0,
    VA48    = 2'd1,
    VA57    = 2'd2,
    VA_BARE = 2'd3
  } va_mode_e;

  typedef enum logic [1:0] {
    K_DATA   = 2'd0,
    K_HYP    = 2'd1,
    K_IFETCH = 2'd2,
    K_TBLJMP = 2'd3
  } acc_kind_e;

  // significant bits of translation mode i: 39, 48, 57
  function automatic int unsigned sig_bits(input int unsigned i);
    return 39 + 9 * i;
  endfunction
endpackage

// File: rtl/pm_priv_sel.sv
module pm_priv_sel
  import pm_xform_pkg::*;
#(
  parameter int unsigned PW = PRIV_W
) (
  input  logic [PW-1:0]      priv,
  input  logic [PW-1:0]      tgt_priv,
  input  logic [1:0]         kind,
  input  logic [2**PW-1:0]   en,
  output logic               mask_on
);
  logic [PW-1:0] gov_priv;
  logic          is_data;

  always_comb begin
    // hypervisor-style accesses follow the level they target (R9)
    gov_priv = (acc_kind_e'(kind) == K_HYP) ? tgt_priv : priv;
    // fetches of either kind are never masked as data (R10)
    is_data  = (acc_kind_e'(kind) == K_DATA) || (acc_kind_e'(kind) == K_HYP);
    // reserved level never masks (R8)
    mask_on  = is_data && (gov_priv != PW'(RSV_PRIV)) && en[gov_priv];
  end
endmodule

// File: rtl/pm_sext.sv
module pm_sext #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned SIG  = 39,
  localparam int unsigned TAG_W = XLEN - 1 - SIG
) (
  input  logic [XLEN-1:0] addr_i,
  input  logic            mask_on,
  output logic [XLEN-1:0] addr_o,
  output logic            fault_o
);
  logic [XLEN-SIG:0] upper;
  logic              top_sig;
  logic              sel_bit;

  always_comb begin
    upper   = addr_i[XLEN-1:SIG-1];
    top_sig = addr_i[SIG-1];
    sel_bit = addr_i[XLEN-1];
    if (mask_on) begin
      addr_o  = {sel_bit, {TAG_W{top_sig}}, addr_i[SIG-1:0]};
      fault_o = sel_bit ^ top_sig;
    end else begin
      addr_o  = addr_i;
      fault_o = !((&upper) || !(|upper));
    end
  end
endmodule

// File: rtl/pm_addr_xform.sv
module pm_addr_xform
  import pm_xform_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned PW   = PRIV_W,
  localparam int unsigned NEN = 2**PW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [XLEN-1:0] req_addr,
  input  logic [1:0]      req_mode,
  input  logic [PW-1:0]   req_priv,
  input  logic [PW-1:0]   req_tgt_priv,
  input  logic [1:0]      req_kind,
  input  logic [NEN-1:0]  pm_en,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rsp_addr,
  output logic            rsp_fault,
  output logic [XLEN-1:0] rsp_tval
);
  logic            mask_on;
  logic [XLEN-1:0] cand_addr  [NUM_SV_MODES+1];
  logic            cand_fault [NUM_SV_MODES+1];
  logic [XLEN-1:0] addr_d, tval_d;
  logic            fault_d;
  logic            valid_q, fault_q;
  logic [XLEN-1:0] addr_q, tval_q;

  pm_priv_sel #(.PW(PW)) u_sel (
    .priv    (req_priv),
    .tgt_priv(req_tgt_priv),
    .kind    (req_kind),
    .en      (pm_en),
    .mask_on (mask_on)
  );

  for (genvar g = 0; g < NUM_SV_MODES; g++) begin : g_mode
    pm_sext #(.XLEN(XLEN), .SIG(sig_bits(g))) u_sext (
      .addr_i (req_addr),
      .mask_on(mask_on),
      .addr_o (cand_addr[g]),
      .fault_o(cand_fault[g])
    );
  end

  // bare setting: no transform, no check (R6)
  assign cand_addr[NUM_SV_MODES]  = req_addr;
  assign cand_fault[NUM_SV_MODES] = 1'b0;

  always_comb begin
    addr_d  = cand_addr[req_mode];
    fault_d = cand_fault[req_mode];
    tval_d  = fault_d ? addr_d : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      fault_q <= 1'b0;
      tval_q  <= '0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        addr_q  <= addr_d;
        fault_q <= fault_d;
        tval_q  <= tval_d;
      end
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_addr  = addr_q;
  assign rsp_fault = fault_q;
  assign rsp_tval  = tval_q;

  p_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_addr) && $stable(rsp_tval)));
  p_sel_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_addr[XLEN-1] == $past(req_addr[XLEN-1]));
  p_bare_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'd3) |=> (!rsp_fault && rsp_addr == $past(req_addr)));
  p_tval_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_tval == rsp_addr);
  p_tval_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> rsp_tval == '0);
  p_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind[1]) |=> rsp_addr == $past(req_addr));
endmodule

// File: tb/pm_addr_xform_test.sv
module pm_addr_xform_test;
  typedef struct packed {
    logic [63:0] addr;
    logic [1:0]  mode;
    logic [1:0]  priv;
    logic [1:0]  tgt;
    logic [1:0]  kind;
    logic [3:0]  en;
    logic [63:0] exp_addr;
    logic        exp_fault;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    // R3 R8: 39-bit, user masked, tag cleared
    '{64'h5A00_0012_3456_7890, 2'd0, 2'd0, 2'd0, 2'd0, 4'b0001, 64'h0000_0012_3456_7890, 1'b0},
    // R3: 39-bit, upper half, tag filled with ones
    '{64'hFF00_00C0_0000_1000, 2'd0, 2'd0, 2'd0, 2'd0, 4'b0001, 64'hFFFF_FFC0_0000_1000, 1'b0},
    // R4: bit 63 disagrees with bit 38
    '{64'h8000_0000_0000_0040, 2'd0, 2'd0, 2'd0, 2'd0, 4'b0001, 64'h8000_0000_0000_0040, 1'b1},
    // R3 R8: 48-bit, supervisor masked
    '{64'h3C00_7FFF_0000_0008, 2'd1, 2'd1, 2'd0, 2'd0, 4'b0010, 64'h0000_7FFF_0000_0008, 1'b0},
    // R3 R8: 57-bit, machine masked, six tag bits
    '{64'h7E00_0000_0000_0100, 2'd2, 2'd3, 2'd0, 2'd0, 4'b1000, 64'h0000_0000_0000_0100, 1'b0},
    // R3: 57-bit upper half
    '{64'hC100_0000_0000_0000, 2'd2, 2'd3, 2'd0, 2'd0, 4'b1000, 64'hFF00_0000_0000_0000, 1'b0},
    // R5 R8: user enable off, tagged address faults unchanged
    '{64'h5A00_0012_3456_7890, 2'd0, 2'd0, 2'd0, 2'd0, 4'b1110, 64'h5A00_0012_3456_7890, 1'b1},
    // R5: enable off, canonical upper address
    '{64'hFFFF_FFC0_0000_0000, 2'd0, 2'd0, 2'd0, 2'd0, 4'b0000, 64'hFFFF_FFC0_0000_0000, 1'b0},
    // R9: hypervisor access from S targeting U uses U enable
    '{64'h5A00_0012_3456_7890, 2'd0, 2'd1, 2'd0, 2'd1, 4'b0001, 64'h0000_0012_3456_7890, 1'b0},
    // R9: only S enabled, target U -> unmasked
    '{64'h5A00_0012_3456_7890, 2'd0, 2'd1, 2'd0, 2'd1, 4'b0010, 64'h5A00_0012_3456_7890, 1'b1},
    // R10: instruction fetch not masked
    '{64'h5A00_0012_3456_7890, 2'd0, 2'd0, 2'd0, 2'd2, 4'b1111, 64'h5A00_0012_3456_7890, 1'b1},
    // R10: table-jump fetch not masked
    '{64'h5A00_0012_3456_7890, 2'd0, 2'd0, 2'd0, 2'd3, 4'b1111, 64'h5A00_0012_3456_7890, 1'b1},
    // R6: bare mode
    '{64'h5A00_0012_3456_7890, 2'd3, 2'd0, 2'd0, 2'd0, 4'b1111, 64'h5A00_0012_3456_7890, 1'b0},
    // R8: reserved level 2 never masks
    '{64'h5A00_0012_3456_7890, 2'd0, 2'd2, 2'd0, 2'd0, 4'b1111, 64'h5A00_0012_3456_7890, 1'b1},
    // R5: 48-bit unmasked, bit 47 set with bit 63 clear
    '{64'h0000_8000_0000_0000, 2'd1, 2'd1, 2'd0, 2'd0, 4'b0000, 64'h0000_8000_0000_0000, 1'b1}
  };

  logic        clk, rst_n, req_valid;
  logic [63:0] req_addr;
  logic [1:0]  req_mode, req_priv, req_tgt_priv, req_kind;
  logic [3:0]  pm_en;
  logic        rsp_valid, rsp_fault;
  logic [63:0] rsp_addr, rsp_tval;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  pm_addr_xform uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_mode(req_mode), .req_priv(req_priv), .req_tgt_priv(req_tgt_priv),
    .req_kind(req_kind), .pm_en(pm_en), .rsp_valid(rsp_valid),
    .rsp_addr(rsp_addr), .rsp_fault(rsp_fault), .rsp_tval(rsp_tval)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] a, input logic [1:0] m, input logic [1:0] p,
                      input logic [1:0] t, input logic [1:0] k, input logic [3:0] e);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_mode = m; req_priv = p;
    req_tgt_priv = t; req_kind = k; pm_en = e;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] first_a, held;
    rst_n = 0; req_valid = 0; req_addr = '0; req_mode = 0; req_priv = 0;
    req_tgt_priv = 0; req_kind = 0; pm_en = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", 64'(rsp_valid), 64'd0);
    check("R1 addr", rsp_addr, 64'd0);
    check("R1 tval", rsp_tval, 64'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 fault after release", 64'(rsp_fault), 64'd0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].addr, VEC[i].mode, VEC[i].priv, VEC[i].tgt, VEC[i].kind, VEC[i].en);
      check($sformatf("R2 valid vec%0d", i), 64'(rsp_valid), 64'd1);
      check($sformatf("R3-R10 addr vec%0d", i), rsp_addr, VEC[i].exp_addr);
      check($sformatf("R4 fault vec%0d", i), 64'(rsp_fault), 64'(VEC[i].exp_fault));
      check($sformatf("R7 tval vec%0d", i), rsp_tval,
            VEC[i].exp_fault ? VEC[i].exp_addr : 64'd0);
    end

    // R2: idle cycle clears valid and holds the result
    held = rsp_addr;
    req_addr = 64'h1234_5678_9ABC_DEF0;
    @(negedge clk);
    check("R2 idle valid", 64'(rsp_valid), 64'd0);
    check("R2 hold addr", rsp_addr, held);
    check("R2 hold fault", 64'(rsp_fault), 64'd1);

    // R11: split misaligned access, 57-bit machine masked
    send(64'h7E00_0000_0000_0FFC, 2'd2, 2'd3, 2'd0, 2'd0, 4'b1000);
    first_a = rsp_addr;
    check("R11 first half", first_a, 64'h0000_0000_0000_0FFC);
    send(64'h7E00_0000_0000_1000, 2'd2, 2'd3, 2'd0, 2'd0, 4'b1000);
    check("R11 second half", rsp_addr, first_a + 64'd4);
    check("R11 no fault", 64'(rsp_fault), 64'd0);

    // R3: 39-bit with bit 63 set and bit 38 set plus a mixed tag
    send(64'hA5A5_A5C0_0000_0001, 2'd0, 2'd3, 2'd0, 2'd0, 4'b1000);
    check("R3 tag fill ones", rsp_addr, 64'hFFFF_FFC0_0000_0001);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule